// File: doc/BRIEF.md
# High-Side Switch Fault Supervisor

This block watches over a bank of high-side load switches. Each switch owns a small control field: zero means off and any other value means the switch is allowed to drive. The block takes a per-switch over-current detector input and a per-switch open-load detector input, plus one supply over-voltage and one supply under-voltage comparator input. From these it decides, cycle by cycle, whether each switch may drive its output.

Over-current goes through two stages. The first is a qualification filter, which sets a sticky interrupt flag. The second is a persistence timer, which clears the switch's control field and pulses a clear strobe. After that shutdown a lockout window rejects rewrites of that field, so the switch can never restart by itself. Open-load only raises a flag. A supply event masks every switch. When the event ends, the switches either come back to their programmed state or have their fields wiped, depending on a restore setting. Each supply direction can be excluded from masking.

Flags are held in one register and cleared by writing ones.

Top module: `hss_fault_sup`

## Requirements
- R1: After reset every output is zero: `sw_en`, `ctrl_clr`, `ctrl_q` and `flags`.
- R2: `flags[i]` (the over-current flag of switch i) becomes 1 after `oc_det[i]` has been sampled high on FILT_CYC consecutive edges while `sw_en[i]` was 1. A shorter burst sets nothing.
- R3: If those samples continue for OFF_CYC more edges (FILT_CYC+OFF_CYC in all), the field of switch i becomes zero and `sw_en[i]` drops at that edge. `ctrl_clr[i]` is high for exactly that one following cycle.
- R4: If `oc_det[i]` falls before the shutdown edge, the switch stays enabled and its field is unchanged.
- R5: Writes to switch i sampled on the OFF_CYC edges that follow its shutdown edge are ignored, and the field stays zero. The next write is accepted.
- R6: `flags[N+i]` (the open-load flag of switch i) sets on any edge where `ol_det[i]` is sampled high. It never changes `sw_en[i]` or the field.
- R7: Flags are sticky. Writing 1 to bit b through `flag_clr_wr`/`flag_clr_mask` clears it, unless its set condition is present on that same edge, in which case it stays 1.
- R8: An unmasked supply event (`sup_ov & ~cfg_ov_dis` or `sup_uv & ~cfg_uv_dis`) sampled on an edge forces every `sw_en` to 0 from that edge. The control fields keep their values.
- R9: With `cfg_restore`=1, on the first edge without a supply event every switch with a nonzero field is enabled again.
- R10: With `cfg_restore`=0, on that first edge every field is cleared to zero. `ctrl_clr[i]` pulses for each switch whose field was nonzero.
- R11: `cfg_ov_dis`=1 makes `sup_ov` have no effect on `sw_en`. `cfg_uv_dis`=1 does the same for `sup_uv`.
- R12: `ctrl_wr[i]` loads `ctrl_wdata` into field i (`ctrl_q[i*CTRL_W +: CTRL_W]`). `sw_en[i]` is 1 exactly when that field is nonzero and no supply mask is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_det | input | NUM_SW | Raw over-current detector per switch |
| ol_det | input | NUM_SW | Open-load detector per switch |
| sup_ov | input | 1 | Supply over-voltage comparator |
| sup_uv | input | 1 | Supply under-voltage comparator |
| cfg_ov_dis | input | 1 | Exclude over-voltage from masking |
| cfg_uv_dis | input | 1 | Exclude under-voltage from masking |
| cfg_restore | input | 1 | 1: restore fields after a supply event; 0: wipe them |
| ctrl_wr | input | NUM_SW | Per-switch control field write strobe |
| ctrl_wdata | input | CTRL_W | Value written to the selected fields |
| flag_clr_wr | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 2*NUM_SW | Ones select flags to clear |
| sw_en | output | NUM_SW | Per-switch drive permission |
| ctrl_clr | output | NUM_SW | One-cycle strobe when a field is cleared by the block |
| ctrl_q | output | NUM_SW*CTRL_W | Packed control fields |
| flags | output | 2*NUM_SW | Over-current flags in [NUM_SW-1:0], open-load flags above |

## Verification
The hardest state to reach is the lockout window. The bench can only get there by holding an over-current on an enabled switch for exactly FILT_CYC+OFF_CYC edges. It then issues rewrites on every edge of the window and one edge past it, so that it hits both the last rejected edge and the first accepted one. A second awkward point is a flag clear landing on the same edge as a live set condition. The bench reaches it by holding an open-load input high through the clear. The reference model tracks every counter behaviourally, so any drift of one cycle in either over-current stage shows up on the cycle it occurs.

// File: rtl/hss_sup_pkg.sv
package hss_sup_pkg;

   // Width of a counter that must hold values 0..n, never below one bit.
   function automatic int cnt_width(input int n);
      int w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction

   // Per-channel event bundle passed up to the top.
   typedef struct packed {
      logic oc_set;   // over-current flag set request
      logic clr;      // field-cleared strobe
   } chan_evt_t;

endpackage

// File: rtl/hss_oc_chan.sv
module hss_oc_chan
   import hss_sup_pkg::*;
#(
   parameter int CTRL_W   = 3,
   parameter int FILT_CYC = 16,
   parameter int OFF_CYC  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oc_det,
   input  logic              mask,
   input  logic              rec_clear,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              sw_en,
   output chan_evt_t         evt
);

   localparam int FW = cnt_width(FILT_CYC);
   localparam int OW = cnt_width(OFF_CYC);
   localparam logic [FW-1:0] FILT_TOP  = FW'(FILT_CYC);
   localparam logic [FW-1:0] FILT_EDGE = FW'(FILT_CYC - 1);
   localparam logic [OW-1:0] OFF_LAST  = OW'(OFF_CYC - 1);
   localparam logic [OW-1:0] OFF_LOAD  = OW'(OFF_CYC);

   logic [FW-1:0] filt_cnt;
   logic [OW-1:0] off_cnt;
   logic [OW-1:0] lock_cnt;
   logic          clr_q;
   logic          run, valid, shut, locked;

   assign sw_en  = (|ctrl_q) & ~mask;
   assign run    = oc_det & sw_en;
   assign valid  = run & (filt_cnt == FILT_TOP);
   assign shut   = valid & (off_cnt == OFF_LAST);
   assign locked = (lock_cnt != '0);

   assign evt.oc_set = run & (filt_cnt >= FILT_EDGE);
   assign evt.clr    = clr_q;

   // stage 1: qualification filter, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  filt_cnt <= '0;
      else if (!run)               filt_cnt <= '0;
      else if (filt_cnt != FILT_TOP) filt_cnt <= filt_cnt + 1'b1;
   end

   // stage 2: persistence timer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              off_cnt <= '0;
      else if (valid && !shut) off_cnt <= off_cnt + 1'b1;
      else                     off_cnt <= '0;
   end

   // stage 3: re-enable lockout
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_cnt <= '0;
      else if (shut)   lock_cnt <= OFF_LOAD;
      else if (locked) lock_cnt <= lock_cnt - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   ctrl_q <= '0;
      else if (shut || rec_clear)   ctrl_q <= '0;
      else if (wr_en && !locked)    ctrl_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clr_q <= 1'b0;
      else        clr_q <= shut | (rec_clear & (|ctrl_q));
   end

   // R3
   shut_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shut |=> (ctrl_q == '0) && clr_q);

   // R5
   lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_en) |=> (ctrl_q == '0));

   // R4
   filter_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oc_det |=> (filt_cnt == '0) && (off_cnt == '0));

endmodule

// File: rtl/hss_supply_guard.sv
module hss_supply_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_ov,
   input  logic sup_uv,
   input  logic cfg_ov_dis,
   input  logic cfg_uv_dis,
   input  logic cfg_restore,
   output logic mask_q,
   output logic rec_clear
);

   logic fault;

   assign fault     = (sup_ov & ~cfg_ov_dis) | (sup_uv & ~cfg_uv_dis);
   assign rec_clear = mask_q & ~fault & ~cfg_restore;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= 1'b0;
      else        mask_q <= fault;
   end

   // R8
   supply_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sup_ov && !cfg_ov_dis) || (sup_uv && !cfg_uv_dis)) |=> mask_q);

   // R11
   ov_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ov_dis && !(sup_uv && !cfg_uv_dis)) |=> !mask_q);

endmodule

// File: rtl/hss_flag_bank.sv
module hss_flag_bank #(
   parameter int W            = 8,
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_req,
   input  logic         clr_wr,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] flags_q
);

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic kill;
      assign kill = clr_wr & clr_mask[b];

      if (SET_OVER_CLR) begin : g_set_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[b] <= 1'b0;
            else        flags_q[b] <= set_req[b] | (flags_q[b] & ~kill);
         end
      end else begin : g_clr_wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    flags_q[b] <= 1'b0;
            else if (kill) flags_q[b] <= 1'b0;
            else           flags_q[b] <= flags_q[b] | set_req[b];
         end
      end

      // R7
      sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[b] && !kill) |=> flags_q[b]);
   end

endmodule

// File: rtl/hss_fault_sup.sv
module hss_fault_sup
   import hss_sup_pkg::*;
#(
   parameter int NUM_SW       = 4,
   parameter int CTRL_W       = 3,
   parameter int FILT_CYC     = 16,
   parameter int OFF_CYC      = 64,
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SW-1:0]        oc_det,
   input  logic [NUM_SW-1:0]        ol_det,
   input  logic                     sup_ov,
   input  logic                     sup_uv,
   input  logic                     cfg_ov_dis,
   input  logic                     cfg_uv_dis,
   input  logic                     cfg_restore,
   input  logic [NUM_SW-1:0]        ctrl_wr,
   input  logic [CTRL_W-1:0]        ctrl_wdata,
   input  logic                     flag_clr_wr,
   input  logic [2*NUM_SW-1:0]      flag_clr_mask,
   output logic [NUM_SW-1:0]        sw_en,
   output logic [NUM_SW-1:0]        ctrl_clr,
   output logic [NUM_SW*CTRL_W-1:0] ctrl_q,
   output logic [2*NUM_SW-1:0]      flags
);

   localparam int NFLAG = 2 * NUM_SW;

   if (NUM_SW < 1)   begin : g_bad_num  $error("NUM_SW must be at least 1");   end
   if (CTRL_W < 1)   begin : g_bad_ctrl $error("CTRL_W must be at least 1");   end
   if (FILT_CYC < 1) begin : g_bad_filt $error("FILT_CYC must be at least 1"); end
   if (OFF_CYC < 1)  begin : g_bad_off  $error("OFF_CYC must be at least 1");  end

   logic              mask_q;
   logic              rec_clear;
   logic [NUM_SW-1:0] oc_set;
   logic [NFLAG-1:0]  flag_set;

   hss_supply_guard u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .sup_ov      (sup_ov),
      .sup_uv      (sup_uv),
      .cfg_ov_dis  (cfg_ov_dis),
      .cfg_uv_dis  (cfg_uv_dis),
      .cfg_restore (cfg_restore),
      .mask_q      (mask_q),
      .rec_clear   (rec_clear)
   );

   for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
      chan_evt_t evt;

      hss_oc_chan #(
         .CTRL_W   (CTRL_W),
         .FILT_CYC (FILT_CYC),
         .OFF_CYC  (OFF_CYC)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .oc_det    (oc_det[i]),
         .mask      (mask_q),
         .rec_clear (rec_clear),
         .wr_en     (ctrl_wr[i]),
         .wr_data   (ctrl_wdata),
         .ctrl_q    (ctrl_q[i*CTRL_W +: CTRL_W]),
         .sw_en     (sw_en[i]),
         .evt       (evt)
      );

      assign oc_set[i]   = evt.oc_set;
      assign ctrl_clr[i] = evt.clr;
   end

   assign flag_set = {ol_det, oc_set};

   hss_flag_bank #(
      .W            (NFLAG),
      .SET_OVER_CLR (SET_OVER_CLR)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (flag_set),
      .clr_wr   (flag_clr_wr),
      .clr_mask (flag_clr_mask),
      .flags_q  (flags)
   );

   // R8
   masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> (sw_en == '0));

   // R10
   wipe_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rec_clear |=> (ctrl_q == '0));

   // R6
   open_load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ol_det) |=> ((flags[NFLAG-1:NUM_SW] & $past(ol_det)) == $past(ol_det)));

endmodule

// File: tb/hss_fault_sup_bench.sv
module hss_fault_sup_bench;

   localparam int N   = 4;
   localparam int CW  = 3;
   localparam int F   = 3;
   localparam int OFF = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0]    oc_det = '0, ol_det = '0, ctrl_wr = '0;
   logic            sup_ov = 0, sup_uv = 0, cfg_ov_dis = 0, cfg_uv_dis = 0, cfg_restore = 1;
   logic [CW-1:0]   ctrl_wdata = '0;
   logic            flag_clr_wr = 0;
   logic [2*N-1:0]  flag_clr_mask = '0;
   logic [N-1:0]    sw_en, ctrl_clr;
   logic [N*CW-1:0] ctrl_q;
   logic [2*N-1:0]  flags;

   always #2.5 clk = ~clk;

   hss_fault_sup #(.NUM_SW(N), .CTRL_W(CW), .FILT_CYC(F), .OFF_CYC(OFF)) u_hss_fault_sup (
      .clk(clk), .rst_n(rst_n), .oc_det(oc_det), .ol_det(ol_det),
      .sup_ov(sup_ov), .sup_uv(sup_uv), .cfg_ov_dis(cfg_ov_dis), .cfg_uv_dis(cfg_uv_dis),
      .cfg_restore(cfg_restore), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .flag_clr_wr(flag_clr_wr), .flag_clr_mask(flag_clr_mask),
      .sw_en(sw_en), .ctrl_clr(ctrl_clr), .ctrl_q(ctrl_q), .flags(flags));

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // behavioural reference state
   int m_ctrl [N];
   int m_filt [N];
   int m_off  [N];
   int m_lock [N];
   bit m_clr  [N];
   bit m_flag [2*N];
   bit m_mask;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_ctrl[i] = 0; m_filt[i] = 0; m_off[i] = 0; m_lock[i] = 0; m_clr[i] = 0;
         end
         for (int b = 0; b < 2*N; b++) m_flag[b] = 0;
         m_mask = 0;
      end else begin
         bit fault, wipe;
         bit en [N];
         fault = (sup_ov && !cfg_ov_dis) || (sup_uv && !cfg_uv_dis);
         wipe  = m_mask && !fault && !cfg_restore;
         for (int i = 0; i < N; i++) en[i] = (m_ctrl[i] != 0) && !m_mask;
         for (int i = 0; i < N; i++) begin
            bit hot, qual, kill, ocs;
            hot  = oc_det[i] && en[i];
            qual = hot && (m_filt[i] == F);
            kill = qual && (m_off[i] == OFF - 1);
            ocs  = hot && (m_filt[i] >= F - 1);
            m_clr[i] = kill || (wipe && m_ctrl[i] != 0);
            if (kill || wipe) m_ctrl[i] = 0;
            else if (ctrl_wr[i] && m_lock[i] == 0) m_ctrl[i] = int'(ctrl_wdata);
            if (kill) m_lock[i] = OFF;
            else if (m_lock[i] > 0) m_lock[i]--;
            m_off[i]  = (qual && !kill) ? m_off[i] + 1 : 0;
            m_filt[i] = !hot ? 0 : ((m_filt[i] < F) ? m_filt[i] + 1 : F);
            m_flag[i]   = ocs || (m_flag[i] && !(flag_clr_wr && flag_clr_mask[i]));
            m_flag[N+i] = ol_det[i] || (m_flag[N+i] && !(flag_clr_wr && flag_clr_mask[N+i]));
         end
         m_mask = fault;
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int e_en, e_clr, e_ctrl, e_flg;
         e_en = 0; e_clr = 0; e_ctrl = 0; e_flg = 0;
         for (int i = 0; i < N; i++) begin
            if (m_ctrl[i] != 0 && !m_mask) e_en |= (1 << i);
            if (m_clr[i]) e_clr |= (1 << i);
            e_ctrl |= (m_ctrl[i] << (i*CW));
         end
         for (int b = 0; b < 2*N; b++) if (m_flag[b]) e_flg |= (1 << b);
         check_eq("R12", "model sw_en", int'(sw_en), e_en);
         check_eq("R3", "model ctrl_clr", int'(ctrl_clr), e_clr);
         check_eq("R5", "model ctrl_q", int'(ctrl_q), e_ctrl);
         check_eq("R7", "model flags", int'(flags), e_flg);
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   function automatic int fld(input int i);
      return int'(ctrl_q[i*CW +: CW]);
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      step(3);
      // R1 reset state
      check_eq("R1", "sw_en", int'(sw_en), 0);
      check_eq("R1", "ctrl_clr", int'(ctrl_clr), 0);
      check_eq("R1", "ctrl_q", int'(ctrl_q), 0);
      check_eq("R1", "flags", int'(flags), 0);
      rst_n = 1'b1;
      step(1);

      // R12 program each field individually
      for (int i = 0; i < N; i++) begin
         ctrl_wr = '0; ctrl_wr[i] = 1'b1; ctrl_wdata = CW'(i + 1);
         step(1);
         check_eq("R12", "field written", fld(i), i + 1);
      end
      ctrl_wr = '0;
      step(1);
      check_eq("R12", "all enabled", int'(sw_en), 4'hF);

      // R2 short burst sets nothing
      oc_det[1] = 1'b1; step(F - 1); oc_det[1] = 1'b0; step(1);
      check_eq("R2", "short burst flag", int'(flags[1]), 0);
      // R2 full filter sets the flag
      oc_det[1] = 1'b1; step(F);
      check_eq("R2", "qualified flag", int'(flags[1]), 1);
      // R4 drop before the off-time ends
      step(OFF - 2); oc_det[1] = 1'b0; step(1);
      check_eq("R4", "still enabled", int'(sw_en[1]), 1);
      check_eq("R4", "field kept", fld(1), 2);

      // R7 write-one-to-clear with no fault present
      flag_clr_wr = 1'b1; flag_clr_mask = 8'h02; step(1);
      flag_clr_wr = 1'b0; flag_clr_mask = '0;
      check_eq("R7", "cleared flag", int'(flags[1]), 0);

      // R6 open-load on switch 2 flags only
      ol_det[2] = 1'b1; step(1);
      check_eq("R6", "open-load flag", int'(flags[N+2]), 1);
      check_eq("R6", "switch kept on", int'(sw_en[2]), 1);
      // R7 clear collides with a live set
      flag_clr_wr = 1'b1; flag_clr_mask = 8'h40; step(1);
      flag_clr_wr = 1'b0; flag_clr_mask = '0;
      check_eq("R7", "set beats clear", int'(flags[N+2]), 1);
      ol_det[2] = 1'b0; step(2);
      check_eq("R7", "sticky after fault", int'(flags[N+2]), 1);
      flag_clr_wr = 1'b1; flag_clr_mask = 8'h40; step(1);
      flag_clr_wr = 1'b0; flag_clr_mask = '0;
      check_eq("R7", "cleared after fault", int'(flags[N+2]), 0);

      // R3 full over-current on switch 0
      oc_det[0] = 1'b1; step(F + OFF - 1);
      check_eq("R3", "on before last edge", int'(sw_en[0]), 1);
      step(1);
      check_eq("R3", "field cleared", fld(0), 0);
      check_eq("R3", "clear strobe", int'(ctrl_clr[0]), 1);
      check_eq("R3", "switch off", int'(sw_en[0]), 0);
      oc_det[0] = 1'b0;
      // R5 writes inside the lockout window
      ctrl_wr[0] = 1'b1; ctrl_wdata = 3'd4;
      for (int k = 0; k < OFF; k++) begin
         step(1);
         check_eq("R5", "locked write ignored", fld(0), 0);
         if (k == 0) check_eq("R3", "strobe one cycle", int'(ctrl_clr[0]), 0);
      end
      step(1);
      ctrl_wr = '0;
      check_eq("R5", "write after lockout", fld(0), 4);

      // R8 / R9 over-voltage with restore
      cfg_restore = 1'b1; sup_ov = 1'b1; step(1);
      check_eq("R8", "masked", int'(sw_en), 0);
      check_eq("R8", "field kept", fld(3), 4);
      step(2); sup_ov = 1'b0; step(1);
      check_eq("R9", "restored", int'(sw_en), 4'hF);

      // R10 under-voltage without restore
      cfg_restore = 1'b0; sup_uv = 1'b1; step(2);
      check_eq("R8", "uv masked", int'(sw_en), 0);
      sup_uv = 1'b0; step(1);
      check_eq("R10", "fields wiped", int'(ctrl_q), 0);
      check_eq("R10", "wipe strobes", int'(ctrl_clr), 4'hF);
      step(1);
      check_eq("R10", "stays off", int'(sw_en), 0);

      // R11 disabled supply directions
      ctrl_wr = '1; ctrl_wdata = 3'd2; step(1); ctrl_wr = '0;
      cfg_ov_dis = 1'b1; sup_ov = 1'b1; step(2);
      check_eq("R11", "ov ignored", int'(sw_en), 4'hF);
      sup_ov = 1'b0; cfg_ov_dis = 1'b0;
      cfg_uv_dis = 1'b1; sup_uv = 1'b1; step(2);
      check_eq("R11", "uv ignored", int'(sw_en), 4'hF);
      sup_uv = 1'b0; cfg_uv_dis = 1'b0; step(2);

      done = 1;
      summary();
      $finish;
   end

endmodule